// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two tables. The first is a set of outcome shift registers. Each register records the last K taken/not-taken results for one slice of the branch address, and A address bits choose which register is used. The second is an array of N-bit saturating up/down counters. A counter is chosen by combining the selected history with M branch-address bits. The top bit of that counter gives the guess.

A fetch stage presents a branch PC on the predict port and reads the taken bit one clock later. When the branch resolves, the execute stage returns the PC and the real outcome on the update port. The update trains only the counter that the current history selects, and then shifts the outcome into that history.

Two index styles are chosen at build time:
- Joined: the history forms the upper index bits above the address bits.
- Hashed: the address bits are XORed with the history. This style is normally paired with A = 0, so that one global history register serves all branches.

With A = 0 every branch shares a single history register. Total storage is K·2^A history bits plus N bits per counter entry.

Top module: `bp_correlator`

## Requirements
- R1: After reset every history register is zero and every counter holds the weakly-not-taken value 2^(N-1)-1 (binary 01 for N = 2), so every PC is predicted not taken.
- R2: `pred_taken` is registered. It is 1 exactly when the selected counter is at least 2^(N-1). It refers to the `pred_pc` that was present at the previous rising clock edge.
- R3: An update with outcome taken adds one to the selected counter, saturating at 2^N-1. An update with outcome not taken subtracts one, saturating at 0.
- R4: An update changes only the counter selected by its own PC and the current history of that PC's slice. Every other counter keeps its value.
- R5: An update shifts its outcome (1 = taken) into bit 0 of the history register selected by PC bits [A+1:2], discarding the oldest bit. The other history registers are unchanged.
- R6: In joined mode the counter index is {history, PC[M+1:2]}, with the history in the upper K bits.
- R7: In hashed mode with A = 0 there is one global history register. The counter index is PC[M+1:2] XOR the zero-extended history, which requires K ≤ M.
- R8: PC bits [1:0] have no effect on either the prediction or the update.
- R9: With N = 2, a counter that is saturated towards taken changes its prediction only after two mispredicted updates. One not-taken update leaves it predicting taken.
- R10: When a prediction and an update arrive in the same cycle, the prediction is formed from the table state before that update.
- R11: While `upd_valid` is low, no history and no counter changes, whatever values `upd_pc` and `upd_taken` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pred_pc | input | PC_W | PC of the branch being predicted |
| pred_taken | output | 1 | Registered guess for the previous cycle's `pred_pc` |
| upd_valid | input | 1 | Qualifies the update port |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch, 1 = taken |

## Verification
The checks inside the design assume three things about the inputs:
- Reset is held for at least one clock before traffic starts.
- `upd_taken` is a defined 0 or 1 whenever `upd_valid` is high.
- The parameters keep K ≤ M in hashed mode.

Under these assumptions, the checks verify that each trained counter moves by exactly one step or stays at its rail, that the trained history moves by one shift, and that nothing moves on idle cycles.

The bench meets these assumptions directly:
- It drives every input at the falling edge, and always with defined values.
- It raises `upd_valid` for exactly one cycle per update.
- It holds reset for several cycles at the start.
- It runs a joined per-address instance next to a hashed global instance. It applies identical traffic to both and compares each against its own model of the tables.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic {
    IDX_JOIN = 1'b0,
    IDX_HASH = 1'b1
  } idx_mode_e;

  // One step of an n-bit saturating up/down counter.
  function automatic logic [7:0] sat_step(input logic [7:0] cur, input logic up,
                                          input logic [7:0] top);
    logic [7:0] res;
    if (up) res = (cur == top) ? cur : cur + 8'd1;
    else    res = (cur == 8'd0) ? cur : cur - 8'd1;
    return res;
  endfunction

endpackage

// File: rtl/bp_history_table.sv
module bp_history_table #(
  parameter int A  = 2,
  parameter int K  = 2,
  parameter int SW = (A > 0) ? A : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] p_slot,
  input  logic [SW-1:0] u_slot,
  input  logic          upd_en,
  input  logic          upd_taken,
  output logic [K-1:0]  p_hist,
  output logic [K-1:0]  u_hist
);

  localparam int SLOTS = 1 << A;

  logic [K-1:0] hist_q [SLOTS];
  logic [K-1:0] hist_nx;
  logic [SW-1:0] p_sel, u_sel;

  generate
    if (A > 0) begin : g_sliced
      assign p_sel = p_slot;
      assign u_sel = u_slot;
    end else begin : g_global
      assign p_sel = '0;
      assign u_sel = '0;
    end
  endgenerate

  assign p_hist = hist_q[p_sel];
  assign u_hist = hist_q[u_sel];

  generate
    if (K > 1) begin : g_shift
      assign hist_nx = {u_hist[K-2:0], upd_taken};
    end else begin : g_single
      assign hist_nx = upd_taken;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SLOTS; s++) hist_q[s] <= '0;
    end else if (upd_en) begin
      hist_q[u_sel] <= hist_nx;
    end
  end

  // ---------------- checks ----------------
  logic          chk_v;
  logic [SW-1:0] chk_slot;
  logic [K-1:0]  chk_old;
  logic          chk_t;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_v <= 1'b0;
    end else begin
      chk_v <= upd_en;
    end
    chk_slot <= u_sel;
    chk_old  <= u_hist;
    chk_t    <= upd_taken;
  end

  generate
    if (K > 1) begin : g_chk_shift
      // R5: the trained history is the old one moved up by one with the outcome at bit 0
      p_hist_shift_r5: assert property (@(posedge clk) disable iff (rst)
        chk_v |-> (hist_q[chk_slot] == {chk_old[K-2:0], chk_t}));
    end else begin : g_chk_single
      p_hist_shift_r5: assert property (@(posedge clk) disable iff (rst)
        chk_v |-> (hist_q[chk_slot] == chk_t));
    end
  endgenerate

  // R11: an idle cycle leaves the first history register untouched
  p_hist_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(hist_q[0]));

endmodule

// File: rtl/bp_index.sv
module bp_index
  import bp_pkg::*;
#(
  parameter int        K     = 2,
  parameter int        M     = 4,
  parameter idx_mode_e MODE  = IDX_JOIN,
  parameter int        IDX_W = (MODE == IDX_HASH) ? M : K + M
) (
  input  logic [K-1:0]     hist,
  input  logic [M-1:0]     pcb,
  output logic [IDX_W-1:0] idx
);

  generate
    if (MODE == IDX_JOIN) begin : g_join
      assign idx = {hist, pcb};
    end else if (M > K) begin : g_hash_ext
      assign idx = pcb ^ {{(M-K){1'b0}}, hist};
    end else begin : g_hash_eq
      assign idx = pcb ^ hist[M-1:0];
    end
  endgenerate

  initial begin
    if (MODE == IDX_HASH && K > M)
      $error("hashed index needs K <= M");
  end

endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table #(
  parameter int IDX_W = 6,
  parameter int N     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] p_idx,
  input  logic [IDX_W-1:0] u_idx,
  input  logic             upd_en,
  input  logic             upd_taken,
  output logic             pred_q
);

  localparam int         DEPTH = 1 << IDX_W;
  localparam logic [N-1:0] TOP  = {N{1'b1}};
  localparam logic [N-1:0] INIT = (N > 1) ? TOP >> 1 : '0;

  logic [N-1:0] ctr_q [DEPTH];
  logic [N-1:0] u_cur;
  logic [N-1:0] u_nxt;
  logic [7:0]   step_w;

  assign u_cur  = ctr_q[u_idx];
  assign step_w = bp_pkg::sat_step(8'(u_cur), upd_taken, 8'(TOP));
  assign u_nxt  = step_w[N-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < DEPTH; e++) ctr_q[e] <= INIT;
    end else if (upd_en) begin
      ctr_q[u_idx] <= u_nxt;
    end
  end

  // Registered read of the upper counter bit; reads the state before any same-edge write.
  always_ff @(posedge clk) begin
    if (rst) pred_q <= 1'b0;
    else     pred_q <= ctr_q[p_idx][N-1];
  end

  // ---------------- checks ----------------
  logic             chk_v;
  logic [IDX_W-1:0] chk_idx;
  logic [N-1:0]     chk_old;
  logic             chk_t;

  always_ff @(posedge clk) begin
    if (rst) chk_v <= 1'b0;
    else     chk_v <= upd_en;
    chk_idx <= u_idx;
    chk_old <= u_cur;
    chk_t   <= upd_taken;
  end

  // R3: a trained counter moves one step towards the outcome or sits on its rail
  p_ctr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (chk_v && chk_t) |-> (ctr_q[chk_idx] == ((chk_old == TOP) ? TOP : chk_old + 1'b1)));

  p_ctr_down_r3: assert property (@(posedge clk) disable iff (rst)
    (chk_v && !chk_t) |-> (ctr_q[chk_idx] == ((chk_old == '0) ? '0 : chk_old - 1'b1)));

  // R11: an idle cycle leaves entry zero untouched
  p_ctr_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(ctr_q[0]));

endmodule

// File: rtl/bp_correlator.sv
module bp_correlator
  import bp_pkg::*;
#(
  parameter int        PC_W = 32,
  parameter int        A    = 2,
  parameter int        K    = 2,
  parameter int        M    = 4,
  parameter int        N    = 2,
  parameter idx_mode_e MODE = IDX_JOIN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);

  localparam int SW    = (A > 0) ? A : 1;
  localparam int IDX_W = (MODE == IDX_HASH) ? M : K + M;

  logic [SW-1:0]    p_slot, u_slot;
  logic [K-1:0]     p_hist, u_hist;
  logic [IDX_W-1:0] p_idx, u_idx;

  // Word-aligned PCs: bits [1:0] never reach an index.
  generate
    if (A > 0) begin : g_slot
      assign p_slot = pred_pc[2 +: SW];
      assign u_slot = upd_pc[2 +: SW];
    end else begin : g_noslot
      assign p_slot = '0;
      assign u_slot = '0;
    end
  endgenerate

  bp_history_table #(.A(A), .K(K), .SW(SW)) u_hist_tab (
    .clk       (clk),
    .rst       (rst),
    .p_slot    (p_slot),
    .u_slot    (u_slot),
    .upd_en    (upd_valid),
    .upd_taken (upd_taken),
    .p_hist    (p_hist),
    .u_hist    (u_hist)
  );

  bp_index #(.K(K), .M(M), .MODE(MODE), .IDX_W(IDX_W)) u_pidx (
    .hist (p_hist),
    .pcb  (pred_pc[2 +: M]),
    .idx  (p_idx)
  );

  bp_index #(.K(K), .M(M), .MODE(MODE), .IDX_W(IDX_W)) u_uidx (
    .hist (u_hist),
    .pcb  (upd_pc[2 +: M]),
    .idx  (u_idx)
  );

  bp_counter_table #(.IDX_W(IDX_W), .N(N)) u_ctr_tab (
    .clk       (clk),
    .rst       (rst),
    .p_idx     (p_idx),
    .u_idx     (u_idx),
    .upd_en    (upd_valid),
    .upd_taken (upd_taken),
    .pred_q    (pred_taken)
  );

  // R1: the first prediction out of reset is not taken
  p_reset_pred_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pred_taken);

endmodule

// File: tb/test_bp_correlator.sv
module test_bp_correlator;
  import bp_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pred_pc = '0;
  logic [31:0] upd_pc = '0;
  logic        upd_valid = 1'b0;
  logic        upd_taken = 1'b0;
  logic        pt_j, pt_h;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Joined index, 4 per-address histories: A=2, K=2, M=4, N=2
  bp_correlator #(.PC_W(32), .A(2), .K(2), .M(4), .N(2), .MODE(IDX_JOIN)) i_bp_correlator (
    .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pt_j),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  // Hashed index, single global history: A=0, K=2, M=4, N=2
  bp_correlator #(.PC_W(32), .A(0), .K(2), .M(4), .N(2), .MODE(IDX_HASH)) i_bp_correlator_h (
    .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pt_h),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  always #5 clk = ~clk;

  // Models built from the requirements
  int jh [4];
  int jc [64];
  int gh;
  int gc [16];

  function automatic int j_idx(logic [31:0] pc);
    return jh[pc[3:2]] * 16 + int'(pc[5:2]);   // R6
  endfunction

  function automatic int g_idx(logic [31:0] pc);
    return int'(pc[5:2]) ^ gh;                  // R7
  endfunction

  function automatic int sat(int v, bit t);
    if (t) return (v == 3) ? 3 : v + 1;         // R3
    return (v == 0) ? 0 : v - 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) jh[i] = 0;
    for (int i = 0; i < 64; i++) jc[i] = 1;
    for (int i = 0; i < 16; i++) gc[i] = 1;
    gh = 0;
  endtask

  task automatic model_update(logic [31:0] pc, bit t);
    int ij, ig;
    ij = j_idx(pc);
    ig = g_idx(pc);
    jc[ij] = sat(jc[ij], t);
    gc[ig] = sat(gc[ig], t);
    jh[pc[3:2]] = ((jh[pc[3:2]] << 1) | int'(t)) & 3;   // R5
    gh = ((gh << 1) | int'(t)) & 3;
  endtask

  task automatic chk(input bit act, input bit exp, input string req, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic do_update(logic [31:0] pc, bit t);
    upd_valid = 1'b1;
    upd_pc = pc;
    upd_taken = t;
    @(negedge clk);
    model_update(pc, t);
    upd_valid = 1'b0;
  endtask

  task automatic do_predict(logic [31:0] pc, input string req);
    bit ej, eg;
    pred_pc = pc;
    ej = jc[j_idx(pc)] >= 2;   // R2
    eg = gc[g_idx(pc)] >= 2;
    @(negedge clk);
    chk(pt_j, ej, req, "joined prediction");
    chk(pt_h, eg, req, "hashed prediction");
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    chk(pt_j, 1'b0, "R1", "joined output after reset");
    for (int i = 0; i < 8; i++) do_predict(32'h1000 + i * 4, "R1");
  endtask

  // R9 and R3: saturate one counter, then show it needs two misses to flip.
  task automatic t_hysteresis();
    logic [31:0] pc = 32'h0000_0010;
    for (int i = 0; i < 5; i++) do_update(pc, 1'b1);
    pred_pc = pc; @(negedge clk);
    chk(pt_j, 1'b1, "R3", "saturated counter predicts taken");
    do_update(pc, 1'b0);
    do_update(pc, 1'b1);
    do_update(pc, 1'b1);
    pred_pc = pc; @(negedge clk);
    chk(pt_j, 1'b1, "R9", "one miss keeps taken");
    do_update(pc, 1'b0);
    do_update(pc, 1'b1);
    do_update(pc, 1'b1);
    pred_pc = pc; @(negedge clk);
    chk(pt_j, 1'b0, "R9", "second miss flips to not taken");
    do_predict(pc, "R9");
  endtask

  // R4/R5: training one slice leaves other slices' predictions alone.
  task automatic t_isolation();
    for (int i = 0; i < 4; i++) do_update(32'h0000_0024, 1'b1);
    do_predict(32'h0000_0024, "R5");
    do_predict(32'h0000_0028, "R4");
    do_predict(32'h0000_002C, "R4");
    do_predict(32'h0000_0034, "R6");
    do_predict(32'h0000_0014, "R7");
  endtask

  // R8: low PC bits make no difference.
  task automatic t_low_bits();
    do_update(32'h0000_0043, 1'b1);
    do_update(32'h0000_0041, 1'b1);
    do_update(32'h0000_0042, 1'b1);
    pred_pc = 32'h0000_0040; @(negedge clk);
    begin
      bit a0 = pt_j;
      pred_pc = 32'h0000_0043; @(negedge clk);
      chk(pt_j, a0, "R8", "low bits alter prediction");
    end
    do_predict(32'h0000_0042, "R8");
  endtask

  // R10: same-cycle predict and update sees pre-update state.
  task automatic t_collide();
    logic [31:0] pc = 32'h0000_0058;
    bit ej, eg;
    do_update(pc, 1'b1);
    do_update(pc, 1'b1);
    do_update(pc, 1'b1);
    for (int r = 0; r < 3; r++) begin
      pred_pc = pc;
      ej = jc[j_idx(pc)] >= 2;
      eg = gc[g_idx(pc)] >= 2;
      upd_valid = 1'b1; upd_pc = pc; upd_taken = 1'b0;
      @(negedge clk);
      model_update(pc, 1'b0);
      upd_valid = 1'b0;
      chk(pt_j, ej, "R10", "joined collide");
      chk(pt_h, eg, "R10", "hashed collide");
    end
  endtask

  // R11: junk on the update port with valid low changes nothing.
  task automatic t_idle();
    for (int i = 0; i < 6; i++) begin
      upd_pc = 32'h0000_0004 * i; upd_taken = i[0];
      @(negedge clk);
    end
    for (int i = 0; i < 6; i++) do_predict(32'h0000_0004 * i, "R11");
  endtask

  task automatic t_sweep();
    logic [31:0] lf = 32'hACE1_1234;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      do_update({26'd0, lf[5:0]}, lf[9] | lf[13]);
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      do_predict({26'd0, lf[5:0]}, "R2");
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_hysteresis();
    t_isolation();
    t_low_bits();
    t_collide();
    t_idle();
    t_sweep();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule